// File: doc/BRIEF.md
# Timer Compare Unit with Capture-Halving Channel

This block sits next to a free-running timer counter and turns the counter value into compare events for three channels. Software programs three compare values and a small mode word through a plain register write port. The unit then reports, in every cycle, which channels have hit their compare condition, and it shows the compare value that each channel is using.

Channels one and three each have two modes. In match mode they fire when the counter equals the compare value. In above-threshold mode they give a single pulse when the counter first rises above the compare value. Because that test is made against the live counter, lowering the threshold below the counter mid-period fires a pulse at once. Channel two always matches on equality. When the halving mode is on, every capture event reloads channel two with half the captured count. Those hardware loads skip the preload shadow. After the first capture, software writes to channel two have no effect. With preload on, writes are staged in a shadow copy until the update strobe arrives.

The write port has no back-pressure: every write is taken in the cycle it is presented. All pins are plain control or data signals with no handshake.

Top module: `tcmp_unit`

## Requirements
- R1: After reset, all three active compare values are 0, and all mode bits (above-threshold 1 and 3, halving, preload) are 0.
- R2: Write addresses 0, 1 and 2 select compare channels 1, 2 and 3. With preload off, a write is seen on the matching active-value output from the next cycle on.
- R3: Preload is mode-word bit 3. With preload on, a write to a channel (other than channel 2 in halving mode) leaves the active value unchanged. The next upd_stb copies the staged value into the active value, and a write made in the same cycle as upd_stb is the one that gets copied.
- R4: A channel in match mode asserts its event in exactly the cycles where cnt_en is high and cnt_val equals its active compare value.
- R5: Address 3 writes the mode word: bit 0 sets above-threshold mode for channel 1 and bit 1 sets it for channel 3. In this mode the event is a one-cycle pulse in the first cycle where cnt_en is high and cnt_val is above the compare value. It fires again only after that condition has been false for at least one cycle.
- R6: In above-threshold mode, if the compare value is lowered below the current counter value, the event pulses in the first cycle that the new value is active, with no equality needed.
- R7: Halving mode is mode-word bit 2. While it is set, cap_stb loads channel 2 with cap_val shifted right by one, visible the next cycle, and upd_stb has no effect on channel 2.
- R8: In halving mode, a write to channel 2 before the first capture goes straight to the active value even when preload is on. After a capture, writes to channel 2 are ignored.
- R9: A mode-word write while cnt_en is high updates bits 0, 1 and 3 but keeps the halving bit at its old value.
- R10: Turning halving mode off clears the captured-once state, so after halving mode is turned back on, a write to channel 2 is accepted again.
- R11: If a capture and a write to channel 2 fall in the same cycle in halving mode, the active value becomes the halved capture.
- R12: Channel 2 always uses match mode, whatever the mode-word bits 0 and 1 are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0..2 compare channel, 3 mode word |
| wr_data | input | CW | Write data; mode word uses bits 3:0 |
| cnt_val | input | CW | Current timer counter value |
| cnt_en | input | 1 | Counter running |
| cap_stb | input | 1 | Capture-1 event strobe |
| cap_val | input | CW | Counter value captured with cap_stb |
| upd_stb | input | 1 | Period update strobe for preload transfer |
| cmp_evt | output | 3 | Compare event per channel (bit 0 = channel 1) |
| cmp1_q | output | CW | Active compare value, channel 1 |
| cmp2_q | output | CW | Active compare value, channel 2 |
| cmp3_q | output | CW | Active compare value, channel 3 |

## Verification
Channel 2 can receive a hardware capture load and a software write in the same cycle. The hardware load must win, including before the first capture, when the write alone would have been accepted. The bench provokes this with a directed cycle that drives cap_stb together with a channel-2 write right after halving mode is re-entered. Random stimulus also makes such collisions happen, alongside update strobes. Each case is judged by comparing the next-cycle cmp2_q against a bench model that applies capture over write over update.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  typedef enum logic [1:0] {
    ADR_CMP1 = 2'd0,
    ADR_CMP2 = 2'd1,
    ADR_CMP3 = 2'd2,
    ADR_MODE = 2'd3
  } tcmp_addr_e;

  localparam int unsigned MB_GT1  = 0;
  localparam int unsigned MB_GT3  = 1;
  localparam int unsigned MB_HALF = 2;
  localparam int unsigned MB_PRE  = 3;
  localparam int unsigned MB_W    = 4;
  localparam int unsigned N_CH    = 3;
  localparam int unsigned HALF_CH = 1;
endpackage

// File: rtl/tcmp_mode.sv
module tcmp_mode
  import tcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mode,
  input  logic [MB_W-1:0] mode_data,
  input  logic            cnt_en,
  input  logic            cap_stb,
  output logic            gt1_o,
  output logic            gt3_o,
  output logic            half_o,
  output logic            pre_o,
  output logic            first_o
);
  logic gt1_q, gt3_q, half_q, pre_q, first_q;
  logic half_d, first_d;

  always_comb begin
    half_d = half_q;
    if (wr_mode && !cnt_en) half_d = mode_data[MB_HALF];
    if (!half_d)                 first_d = 1'b0;
    else if (half_q && cap_stb)  first_d = 1'b1;
    else                         first_d = first_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gt1_q   <= 1'b0;
      gt3_q   <= 1'b0;
      half_q  <= 1'b0;
      pre_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (wr_mode) begin
        gt1_q <= mode_data[MB_GT1];
        gt3_q <= mode_data[MB_GT3];
        pre_q <= mode_data[MB_PRE];
      end
      half_q  <= half_d;
      first_q <= first_d;
    end
  end

  assign gt1_o   = gt1_q;
  assign gt3_o   = gt3_q;
  assign half_o  = half_q;
  assign pre_o   = pre_q;
  assign first_o = first_q;

  // R9: halving bit frozen while the counter runs
  a_r9_half_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> $stable(half_q));
  // R10: captured-once state never survives leaving halving mode
  a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !half_q |-> !first_q);
endmodule

// File: rtl/tcmp_value.sv
module tcmp_value #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hit,
  input  logic [CW-1:0] wr_data,
  input  logic          pre_en,
  input  logic          upd,
  input  logic          hw_mode,
  input  logic          hw_locked,
  input  logic          hw_ld,
  input  logic [CW-1:0] ld_val,
  output logic [CW-1:0] act_o
);
  logic [CW-1:0] act_q, sh_q, act_d, sh_d;
  logic          pre_eff;

  assign pre_eff = pre_en && !hw_mode;

  always_comb begin
    act_d = act_q;
    sh_d  = sh_q;
    if (upd && pre_eff) act_d = wr_hit ? wr_data : sh_q;
    if (wr_hit) begin
      if (hw_mode) begin
        if (!hw_locked) begin
          act_d = wr_data;
          sh_d  = wr_data;
        end
      end else if (pre_eff) begin
        sh_d = wr_data;
      end else begin
        act_d = wr_data;
        sh_d  = wr_data;
      end
    end
    if (hw_ld) act_d = ld_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      sh_q  <= '0;
    end else begin
      act_q <= act_d;
      sh_q  <= sh_d;
    end
  end

  assign act_o = act_q;

  // R3: active value moves only on write, update or hardware load
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hit && !upd && !hw_ld) |=> $stable(act_q));
  // R7: hardware load lands the next cycle
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ld |=> (act_q == $past(ld_val)));
  // R8: locked channel ignores software and update
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && hw_locked && !hw_ld) |=> $stable(act_q));
endmodule

// File: rtl/tcmp_event.sv
module tcmp_event #(
  parameter int unsigned CW    = 16,
  parameter bit          GT_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gt_mode,
  input  logic          cnt_en,
  input  logic [CW-1:0] cnt_val,
  input  logic [CW-1:0] cmp_val,
  output logic          evt_o
);
  logic above, prev_q, use_gt;

  assign above  = cnt_en && (cnt_val > cmp_val);
  assign use_gt = GT_OK && gt_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= above;
  end

  assign evt_o = use_gt ? (above && !prev_q)
                        : (cnt_en && (cnt_val == cmp_val));

  // R5: above-threshold event never lasts two cycles
  a_r5_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (use_gt && evt_o) |=> !(use_gt && evt_o));
endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_en,
  input  logic          cap_stb,
  input  logic [CW-1:0] cap_val,
  input  logic          upd_stb,
  output logic [2:0]    cmp_evt,
  output logic [CW-1:0] cmp1_q,
  output logic [CW-1:0] cmp2_q,
  output logic [CW-1:0] cmp3_q
);
  logic          gt1, gt3, half, pre, first;
  logic [CW-1:0] ld_val;
  logic [CW-1:0] act [N_CH];
  tcmp_addr_e    addr;

  assign addr   = tcmp_addr_e'(wr_addr);
  assign ld_val = cap_val >> 1;

  tcmp_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode   (wr_en && (addr == ADR_MODE)),
    .mode_data (wr_data[MB_W-1:0]),
    .cnt_en    (cnt_en),
    .cap_stb   (cap_stb),
    .gt1_o     (gt1),
    .gt3_o     (gt3),
    .half_o    (half),
    .pre_o     (pre),
    .first_o   (first)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam bit IS_HALF = (i == HALF_CH);
    logic hit, gtm;
    assign hit = wr_en && (wr_addr == 2'(i));
    if (i == 0)      begin : g_m1 assign gtm = gt1;  end
    else if (i == 2) begin : g_m3 assign gtm = gt3;  end
    else             begin : g_m2 assign gtm = 1'b0; end

    tcmp_value #(.CW(CW)) u_val (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (hit),
      .wr_data   (wr_data),
      .pre_en    (pre),
      .upd       (upd_stb),
      .hw_mode   (IS_HALF && half),
      .hw_locked (first),
      .hw_ld     (IS_HALF && half && cap_stb),
      .ld_val    (ld_val),
      .act_o     (act[i])
    );

    tcmp_event #(.CW(CW), .GT_OK(!IS_HALF)) u_evt (
      .clk     (clk),
      .rst_n   (rst_n),
      .gt_mode (gtm),
      .cnt_en  (cnt_en),
      .cnt_val (cnt_val),
      .cmp_val (act[i]),
      .evt_o   (cmp_evt[i])
    );
  end

  assign cmp1_q = act[0];
  assign cmp2_q = act[1];
  assign cmp3_q = act[2];

  // R12: channel 2 fires only on equality
  a_r12_ch2_equal: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt[1] |-> (cnt_en && (cnt_val == cmp2_q)));
  // R4: channel 1 in match mode fires only on equality
  a_r4_ch1_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!gt1 && cmp_evt[0]) |-> (cnt_val == cmp1_q));
endmodule

// File: tb/sim_tcmp_unit.sv
module sim_tcmp_unit;
  localparam int unsigned CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] cnt_val = '0;
  logic          cnt_en = 1'b0;
  logic          cap_stb = 1'b0;
  logic [CW-1:0] cap_val = '0;
  logic          upd_stb = 1'b0;
  logic [2:0]    cmp_evt;
  logic [CW-1:0] cmp1_q, cmp2_q, cmp3_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcmp_unit #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_val(cnt_val), .cnt_en(cnt_en),
    .cap_stb(cap_stb), .cap_val(cap_val), .upd_stb(upd_stb),
    .cmp_evt(cmp_evt), .cmp1_q(cmp1_q), .cmp2_q(cmp2_q), .cmp3_q(cmp3_q)
  );

  // reference model state
  logic [CW-1:0] m_act [3];
  logic [CW-1:0] m_sh  [3];
  logic          m_prev [3];
  logic m_gt1, m_gt3, m_half, m_pre, m_first;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic m_above(int i);
    return cnt_en && (cnt_val > m_act[i]);
  endfunction

  function automatic logic m_evt(int i);
    logic gtm;
    gtm = (i == 0) ? m_gt1 : (i == 2) ? m_gt3 : 1'b0;
    if (gtm) return m_above(i) && !m_prev[i];
    return cnt_en && (cnt_val == m_act[i]);
  endfunction

  function automatic logic [CW-1:0] dut_val(int i);
    return (i == 0) ? cmp1_q : (i == 1) ? cmp2_q : cmp3_q;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_act[i] = '0; m_sh[i] = '0; m_prev[i] = 1'b0;
    end
    {m_gt1, m_gt3, m_half, m_pre, m_first} = '0;
  endtask

  task automatic compare_all();
    chk("R2 ch1 value", cmp1_q, m_act[0]);
    chk("R7 ch2 value", cmp2_q, m_act[1]);
    chk("R2 ch3 value", cmp3_q, m_act[2]);
    chk(m_gt1 ? "R5 ch1 event" : "R4 ch1 event", cmp_evt[0], m_evt(0));
    chk("R12 ch2 event", cmp_evt[1], m_evt(1));
    chk(m_gt3 ? "R5 ch3 event" : "R4 ch3 event", cmp_evt[2], m_evt(2));
  endtask

  // one clock: check now, compute next state, advance, clear strobes
  task automatic step();
    logic [CW-1:0] na [3];
    logic [CW-1:0] ns [3];
    logic          np [3];
    logic nhalf, nfirst, hit, hw, pe;
    #1;
    compare_all();
    nhalf = m_half;
    if (wr_en && wr_addr == 2'd3 && !cnt_en) nhalf = wr_data[2];
    nfirst = !nhalf ? 1'b0 : (m_half && cap_stb) ? 1'b1 : m_first;
    for (int i = 0; i < 3; i++) begin
      hit = wr_en && (wr_addr == 2'(i));
      hw  = (i == 1) && m_half;
      pe  = m_pre && !hw;
      na[i] = m_act[i]; ns[i] = m_sh[i];
      np[i] = m_above(i);
      if (upd_stb && pe) na[i] = hit ? wr_data : m_sh[i];
      if (hit) begin
        if (hw) begin
          if (!m_first) begin na[i] = wr_data; ns[i] = wr_data; end
        end else if (pe) ns[i] = wr_data;
        else begin na[i] = wr_data; ns[i] = wr_data; end
      end
      if (hw && cap_stb) na[i] = cap_val >> 1;
    end
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      m_act[i] = na[i]; m_sh[i] = ns[i]; m_prev[i] = np[i];
    end
    if (wr_en && wr_addr == 2'd3) begin
      m_gt1 = wr_data[0]; m_gt3 = wr_data[1]; m_pre = wr_data[3];
    end
    m_half = nhalf; m_first = nfirst;
    @(negedge clk);
    wr_en = 1'b0; cap_stb = 1'b0; upd_stb = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [CW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic mode(bit g1, bit g3, bit h, bit p);
    wr(2'd3, CW'({p, h, g3, g1}));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd7));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 ch1 reset", cmp1_q, 0);
    chk("R1 ch2 reset", cmp2_q, 0);
    chk("R1 ch3 reset", cmp3_q, 0);
    // R2: direct write
    wr(2'd0, 16'd5);
    chk("R2 direct write", cmp1_q, 5);
    // R3: preload staging and transfer
    mode(0, 0, 0, 1);
    wr(2'd2, 16'd9);
    chk("R3 staged not active", cmp3_q, 0);
    upd_stb = 1'b1; step();
    chk("R3 update transfer", cmp3_q, 9);
    // R4: match mode
    cnt_en = 1'b1; cnt_val = 16'd5; #1;
    chk("R4 equal fires", cmp_evt[0], 1);
    cnt_val = 16'd6; #1;
    chk("R4 above silent", cmp_evt[0], 0);
    cnt_val = 16'd4; step();
    // R5: above-threshold pulse
    mode(1, 0, 0, 1);
    cnt_val = 16'd6; #1;
    chk("R5 first above pulses", cmp_evt[0], 1);
    step(); #1;
    chk("R5 no repeat", cmp_evt[0], 0);
    // R6: on-the-fly lowering
    mode(1, 0, 0, 0);
    wr(2'd0, 16'd20);
    step();
    wr(2'd0, 16'd3); #1;
    chk("R6 lowered threshold pulses", cmp_evt[0], 1);
    step();
    // R7/R8: halving mode
    cnt_en = 1'b0;
    mode(0, 0, 1, 1);
    wr(2'd1, 16'd7);
    chk("R8 initial write accepted", cmp2_q, 7);
    cap_stb = 1'b1; cap_val = 16'd41; step();
    chk("R7 halved capture", cmp2_q, 20);
    wr(2'd1, 16'd99);
    chk("R8 write after capture ignored", cmp2_q, 20);
    upd_stb = 1'b1; step();
    chk("R7 update ignored", cmp2_q, 20);
    // R9: halving bit locked while counting
    cnt_en = 1'b1; cnt_val = 16'd0;
    mode(0, 0, 0, 1);
    cap_stb = 1'b1; cap_val = 16'd10; step();
    chk("R9 halving stayed on", cmp2_q, 5);
    // R10: re-entry accepts write again
    cnt_en = 1'b0;
    mode(0, 0, 0, 0);
    mode(0, 0, 1, 0);
    wr(2'd1, 16'd33);
    chk("R10 write after re-entry", cmp2_q, 33);
    // R11: capture beats same-cycle write
    mode(0, 0, 0, 0);
    mode(0, 0, 1, 0);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd50;
    cap_stb = 1'b1; cap_val = 16'd80; step();
    chk("R11 capture wins", cmp2_q, 40);
    // R12: channel 2 equality only
    cnt_en = 1'b1;
    mode(1, 1, 0, 0);
    cnt_val = 16'd40; #1;
    chk("R12 equal fires", cmp_evt[1], 1);
    cnt_val = 16'd41; #1;
    chk("R12 above silent", cmp_evt[1], 0);
    step();
    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      cnt_en  = ($urandom_range(0, 9) < 8);
      if ($urandom_range(0, 9) < 3) begin
        wr_en   = 1'b1;
        wr_addr = 2'($urandom_range(0, 3));
        wr_data = CW'($urandom_range(0, 63));
      end
      cap_stb = ($urandom_range(0, 9) == 0);
      cap_val = CW'($urandom_range(0, 127));
      upd_stb = ($urandom_range(0, 9) == 0);
      step();
      if (cnt_en) cnt_val = (cnt_val == 16'd63) ? '0 : cnt_val + 16'd1;
    end
    done = 1'b1;
    finish_run();
  end
endmodule